// File: doc/BRIEF.md
# Event Routing Channel

One channel of an event routing fabric. A 32-bit configuration word picks one of up to 256 generator lines. The selected line goes to the channel output by one of two routes. The direct route is purely combinational and forwards the raw level. The synchronized route samples the level into the channel clock domain through two flops and a history flop. It then turns the chosen edge type into a pulse one clock wide.

The channel also drives a clock request. In always-on mode the request is held for as long as the channel is configured. In on-demand mode it is raised only while an event is in flight. A standby input silences the channel unless the configuration allows it to run in standby. The register is written as one whole 32-bit word and can be read back at any time.

Top module: `evt_chan`

## Requirements
- R1: After reset the read-back word is 0x00008000, meaning on-demand is set and every other field is zero.
- R2: A write stores on-demand (bit 15), run-in-standby (bit 14), edge select (bits 11:10), route select (bits 9:8) and generator select (bits 7:0) all at once. Every other bit reads back as zero.
- R3: With route code 0 (direct), the output equals the level of the selected generator in the same cycle, and the edge select field has no effect.
- R4: With route code 1 (synchronized) and edge code 1 (rising), a rising input yields a one-cycle output pulse in the third clock cycle after the change, and a falling input yields none.
- R5: With edge code 2 (falling), only a falling input yields the one-cycle pulse, with the same latency as R4.
- R6: With edge code 3 (both), either edge yields a pulse. With edge code 0, the synchronized route never produces output.
- R7: Route codes 2 and 3 are reserved and disable the channel: the output stays low.
- R8: Generator select 0 connects nothing: the output stays low and no clock request is made.
- R9: In standby with run-in-standby clear, the output and the clock request are both low. With run-in-standby set, the channel keeps producing pulses.
- R10: With on-demand clear, the clock request is high continuously while the channel has a valid route and a nonzero generator.
- R11: With on-demand set, the clock request rises in the same cycle as a change of the selected raw input. It falls on the fourth clock edge after the change, once the pulse has been issued and every synchronizer stage agrees with the input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Full-word configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read-back |
| gen_in | input | NUM_GEN | Event generator lines |
| standby | input | 1 | Standby sleep indication |
| evt_out | output | 1 | Channel event output |
| clk_req | output | 1 | Channel clock request |

## Verification
The hardest case to reach is the on-demand clock request. It must rise without a clock edge and fall only once the last synchronizer stage, the history flop and the pulse have all caught up with the input. The bench changes a generator line at the falling clock edge and checks the request one time step later, before any rising edge. It then counts rising edges to show the request is still high after the third and low after the fourth. Every configuration switch is followed by settling cycles, so that the synchronizer does not turn a stale level into an extra pulse.

// File: rtl/evt_chan_pkg.sv
package evt_chan_pkg;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2,
        EDGE_BOTH = 2'd3
    } edge_e;

    typedef enum logic [1:0] {
        ROUTE_DIRECT = 2'd0,
        ROUTE_SYNC   = 2'd1,
        ROUTE_RSV2   = 2'd2,
        ROUTE_RSV3   = 2'd3
    } route_e;

    typedef struct packed {
        logic   on_demand;
        logic   run_stby;
        edge_e  edge_sel;
        route_e route;
        logic [7:0] gen_sel;
    } cfg_t;

    localparam logic [31:0] CFG_RESET_WORD = 32'h0000_8000;

    function automatic cfg_t cfg_unpack(input logic [31:0] w);
        cfg_t c;
        c.on_demand = w[15];
        c.run_stby  = w[14];
        c.edge_sel  = edge_e'(w[11:10]);
        c.route     = route_e'(w[9:8]);
        c.gen_sel   = w[7:0];
        return c;
    endfunction

    function automatic logic [31:0] cfg_pack(input cfg_t c);
        return {16'h0000, c.on_demand, c.run_stby, 2'b00,
                c.edge_sel, c.route, c.gen_sel};
    endfunction

    function automatic logic route_valid(input route_e r);
        return (r == ROUTE_DIRECT) || (r == ROUTE_SYNC);
    endfunction

endpackage

// File: rtl/evt_chan_cfg.sv
module evt_chan_cfg
    import evt_chan_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        we,
    input  logic [31:0] wdata,
    output cfg_t        cfg,
    output logic [31:0] rdata
);
    cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst)     cfg_q <= cfg_unpack(CFG_RESET_WORD);
        else if (we) cfg_q <= cfg_unpack(wdata);
    end

    assign cfg   = cfg_q;
    assign rdata = cfg_pack(cfg_q);

    assert_reset_word_R1: assert property (@(posedge clk)
        (!rst && $past(rst)) |-> (rdata == 32'h0000_8000));

    assert_unused_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (rdata[31:16] == 16'h0) && (rdata[13:12] == 2'b00));

endmodule

// File: rtl/evt_chan_sync.sv
module evt_chan_sync
    import evt_chan_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  raw,
    input  logic  enable,
    input  edge_e edge_sel,
    output logic  pulse,
    output logic  busy
);
    logic [STAGES-1:0] sr;
    logic hist;
    logic pulse_q;
    logic s_last;
    logic rise, fall, det;

    always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= {sr[STAGES-2:0], raw};
    end

    assign s_last = sr[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) hist <= 1'b0;
        else     hist <= s_last;
    end

    assign rise = s_last & ~hist;
    assign fall = ~s_last & hist;

    always_comb begin
        unique case (edge_sel)
            EDGE_RISE: det = rise;
            EDGE_FALL: det = fall;
            EDGE_BOTH: det = rise | fall;
            default:   det = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) pulse_q <= 1'b0;
        else     pulse_q <= enable & det;
    end

    assign pulse = pulse_q;
    assign busy  = (|(sr ^ {STAGES{raw}})) | (hist ^ s_last) | pulse_q;

    assert_no_edge_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        (edge_sel == EDGE_NONE) |=> !pulse_q);

    assert_pulse_needs_change_R4: assert property (@(posedge clk) disable iff (rst)
        pulse_q |-> (hist != $past(hist)));

endmodule

// File: rtl/evt_chan_clkreq.sv
module evt_chan_clkreq (
    input  logic configured,
    input  logic active,
    input  logic on_demand,
    input  logic busy,
    output logic clk_req
);
    always_comb begin
        if (!configured || !active) clk_req = 1'b0;
        else if (on_demand)         clk_req = busy;
        else                        clk_req = 1'b1;
    end
endmodule

// File: rtl/evt_chan.sv
module evt_chan
    import evt_chan_pkg::*;
#(
    parameter int NUM_GEN = 256,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic [31:0]        cfg_wdata,
    output logic [31:0]        cfg_rdata,
    input  logic [NUM_GEN-1:0] gen_in,
    input  logic               standby,
    output logic               evt_out,
    output logic               clk_req
);
    cfg_t cfg;
    logic raw, active, configured, pulse, busy;

    evt_chan_cfg u_cfg (
        .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata),
        .cfg(cfg), .rdata(cfg_rdata)
    );

    always_comb begin
        raw = 1'b0;
        for (int i = 1; i < NUM_GEN; i++)
            if (cfg.gen_sel == 8'(i)) raw = gen_in[i];
    end

    assign active     = !standby || cfg.run_stby;
    assign configured = route_valid(cfg.route) && (cfg.gen_sel != 8'd0);

    evt_chan_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .raw(raw),
        .enable(active && cfg.route == ROUTE_SYNC),
        .edge_sel(cfg.edge_sel), .pulse(pulse), .busy(busy)
    );

    evt_chan_clkreq u_req (
        .configured(configured), .active(active), .on_demand(cfg.on_demand),
        .busy(busy), .clk_req(clk_req)
    );

    always_comb begin
        unique case (cfg.route)
            ROUTE_DIRECT: evt_out = active & raw;
            ROUTE_SYNC:   evt_out = pulse;
            default:      evt_out = 1'b0;
        endcase
    end

    assert_reserved_low_R7: assert property (@(posedge clk) disable iff (rst)
        !route_valid(cfg.route) |-> !evt_out);

    assert_standby_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (standby && !cfg.run_stby) |-> (!evt_out && !clk_req));

    assert_nosel_noreq_R8: assert property (@(posedge clk) disable iff (rst)
        (cfg.gen_sel == 8'd0) |-> (!clk_req && !evt_out));

    assert_always_on_R10: assert property (@(posedge clk) disable iff (rst)
        (!cfg.on_demand && configured && !standby) |-> clk_req);

endmodule

// File: tb/evt_chan_tb.sv
module evt_chan_tb;
    localparam int NG = 256;

    logic clk = 1'b0;
    logic rst;
    logic cfg_we;
    logic [31:0] cfg_wdata;
    logic [31:0] cfg_rdata;
    logic [NG-1:0] gen_in;
    logic standby;
    logic evt_out, clk_req;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    evt_chan u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .gen_in(gen_in), .standby(standby),
        .evt_out(evt_out), .clk_req(clk_req)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [31:0] word(input bit od, input bit rs, input logic [1:0] e,
                                         input logic [1:0] p, input logic [7:0] s);
        return {16'h0, od, rs, 2'b00, e, p, s};
    endfunction

    task automatic wr(input logic [31:0] w);
        cfg_we = 1'b1; cfg_wdata = w;
        cyc(1);
        cfg_we = 1'b0; cfg_wdata = '0;
        cyc(4);
    endtask

    // Changes a line at a negedge and checks the pulse window (R4 latency).
    task automatic pulse_probe(input string req, input int idx, input logic v, input bit expect_pulse);
        gen_in[idx] = v;
        cyc(2);
        check(req, {31'b0, evt_out}, 32'd0);
        cyc(1);
        check(req, {31'b0, evt_out}, {31'b0, expect_pulse});
        cyc(1);
        check(req, {31'b0, evt_out}, 32'd0);
        cyc(1);
    endtask

    task automatic t_reset;
        rst = 1'b1; cyc(3); rst = 1'b0; cyc(1);
        check("R1", cfg_rdata, 32'h0000_8000);
        check("R1", {31'b0, evt_out}, 32'd0);
    endtask

    task automatic t_regmap;
        wr(32'hFFFF_FFFF);
        check("R2", cfg_rdata, 32'h0000_CFFF);
        wr(32'h1234_4A5C);
        check("R2", cfg_rdata, 32'h0000_4A5C);
        wr(word(0, 0, 2'd0, 2'd0, 8'd0));
    endtask

    task automatic t_direct;
        wr(word(0, 0, 2'd3, 2'd0, 8'd200));
        gen_in[200] = 1'b1; #1;
        check("R3", {31'b0, evt_out}, 32'd1);
        cyc(3);
        check("R3", {31'b0, evt_out}, 32'd1);
        gen_in[200] = 1'b0; #1;
        check("R3", {31'b0, evt_out}, 32'd0);
        cyc(4);
    endtask

    task automatic t_rise;
        wr(word(0, 0, 2'd1, 2'd1, 8'd5));
        pulse_probe("R4", 5, 1'b1, 1'b1);
        pulse_probe("R4", 5, 1'b0, 1'b0);
    endtask

    task automatic t_fall;
        wr(word(0, 0, 2'd2, 2'd1, 8'd255));
        pulse_probe("R5", 255, 1'b1, 1'b0);
        pulse_probe("R5", 255, 1'b0, 1'b1);
    endtask

    task automatic t_both_none;
        wr(word(0, 0, 2'd3, 2'd1, 8'd7));
        pulse_probe("R6", 7, 1'b1, 1'b1);
        pulse_probe("R6", 7, 1'b0, 1'b1);
        wr(word(0, 0, 2'd0, 2'd1, 8'd7));
        pulse_probe("R6", 7, 1'b1, 1'b0);
        pulse_probe("R6", 7, 1'b0, 1'b0);
    endtask

    task automatic t_reserved;
        wr(word(0, 0, 2'd0, 2'd2, 8'd9));
        gen_in[9] = 1'b1; cyc(4);
        check("R7", {31'b0, evt_out}, 32'd0);
        wr(word(0, 0, 2'd1, 2'd3, 8'd9));
        gen_in[9] = 1'b0; cyc(2);
        check("R7", {31'b0, evt_out}, 32'd0);
        cyc(1);
        check("R7", {31'b0, evt_out}, 32'd0);
        cyc(2);
    endtask

    task automatic t_nosel;
        wr(word(0, 0, 2'd0, 2'd0, 8'd0));
        gen_in[0] = 1'b1; #1;
        check("R8", {31'b0, evt_out}, 32'd0);
        check("R8", {31'b0, clk_req}, 32'd0);
        gen_in[0] = 1'b0; cyc(1);
    endtask

    task automatic t_standby;
        wr(word(0, 0, 2'd1, 2'd1, 8'd12));
        standby = 1'b1;
        pulse_probe("R9", 12, 1'b1, 1'b0);
        check("R9", {31'b0, clk_req}, 32'd0);
        gen_in[12] = 1'b0; cyc(4);
        wr(word(0, 1, 2'd1, 2'd1, 8'd12));
        pulse_probe("R9", 12, 1'b1, 1'b1);
        check("R9", {31'b0, clk_req}, 32'd1);
        standby = 1'b0;
        gen_in[12] = 1'b0; cyc(4);
    endtask

    task automatic t_always_on;
        wr(word(0, 0, 2'd1, 2'd1, 8'd30));
        check("R10", {31'b0, clk_req}, 32'd1);
        cyc(5);
        check("R10", {31'b0, clk_req}, 32'd1);
    endtask

    task automatic t_on_demand;
        wr(word(1, 0, 2'd1, 2'd1, 8'd40));
        check("R11", {31'b0, clk_req}, 32'd0);
        gen_in[40] = 1'b1; #1;
        check("R11", {31'b0, clk_req}, 32'd1);
        cyc(3);
        check("R11", {31'b0, evt_out}, 32'd1);
        check("R11", {31'b0, clk_req}, 32'd1);
        cyc(1);
        check("R11", {31'b0, clk_req}, 32'd0);
        gen_in[40] = 1'b0; #1;
        check("R11", {31'b0, clk_req}, 32'd1);
        cyc(4);
        check("R11", {31'b0, clk_req}, 32'd0);
    endtask

    initial begin
        #(5ns * 20000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cfg_we = 1'b0; cfg_wdata = '0; gen_in = '0; standby = 1'b0;
        @(negedge clk);
        t_reset;
        t_regmap;
        t_direct;
        t_rise;
        t_fall;
        t_both_none;
        t_reserved;
        t_nosel;
        t_standby;
        t_always_on;
        t_on_demand;
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule